// File: doc/BRIEF.md
# Descriptor Chain Fetcher for Memory-to-Stream Transfers

The block walks a linked list of transfer descriptors held in memory. For each descriptor it reads the words one at a time over a single-outstanding read port and gathers the fields. It then validates the control word and the pointers. A valid descriptor becomes one command for a downstream data mover. The command carries the buffer address, the byte count, and the first-of-frame and last-of-frame flags. A frame can therefore span several chained buffers. When the mover reports how many bytes it moved, the block writes a completion word back into the descriptor. It then either follows the next pointer or stops at the programmed tail.

Software starts a walk with a one-cycle start pulse, a first descriptor address and a tail address. The read request, command and status write ports are valid/ready. A valid holds its payload unchanged until ready is seen, and the consumer may stall any of them for any number of cycles. A read response arrives as a single-cycle pulse. The mover's completion report is also a single-cycle pulse, and it is only taken while a command is outstanding.

Top module: `sgdesc_walker`

## Requirements
- R1: For each descriptor the block issues exactly 8 + USER_WORDS word reads, one at a time, at byte addresses base + 4*i for i = 0, 1, 2 and so on in rising order.
- R2: The command address is {word 3, word 2}, the length is control word (word 6) bits 25:0, end-of-frame is control bit 26 and start-of-frame is control bit 27.
- R3: cmd_valid stays high with an unchanged payload until cmd_ready is seen.
- R4: After the mover's completion pulse the block writes base + 0x1C with bit 31 set and bits 25:0 equal to the reported byte count. The other bits are zero. wr_valid holds its payload until wr_ready.
- R5: The next descriptor address is {word 1, word 0}. After the status write of the descriptor whose base equals the tail address, done pulses for one cycle in the same cycle busy falls.
- R6: A descriptor with a length of zero issues no command, writes 0x4000_0000 to base + 0x1C, pulses err for one cycle and halts. done and err never assert together.
- R7: A buffer address whose low log2(DATA_BYTES) bits are not zero is handled as in R6.
- R8: A next pointer that is not 64-byte aligned is handled as in R6, unless the descriptor is the tail, in which case it is never used.
- R9: busy rises the cycle after an accepted start and stays high until done or err. A start while busy has no effect on the walk.
- R10: After reset busy, done, err, rd_valid, cmd_valid and wr_valid are all low.
- R11: rd_valid stays high with an unchanged rd_addr until rd_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| first_addr | input | 64 | Base of the first descriptor |
| tail_addr | input | 64 | Base of the last descriptor to process |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: tail descriptor finished |
| err | output | 1 | One-cycle pulse: walk halted on a bad descriptor |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 64 | Read byte address |
| rd_rsp_valid | input | 1 | Read data pulse |
| rd_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_addr | output | 64 | Buffer address |
| cmd_len | output | 26 | Buffer length in bytes |
| cmd_sof | output | 1 | First buffer of a frame |
| cmd_eof | output | 1 | Last buffer of a frame |
| mv_done_valid | input | 1 | Mover completion pulse |
| mv_done_bytes | input | 26 | Bytes actually moved |
| wr_valid | output | 1 | Status write valid |
| wr_ready | input | 1 | Status write accepted |
| wr_addr | output | 64 | Status write byte address |
| wr_data | output | 32 | Status word |

## Verification
A read request appears the cycle after start is accepted, or after the previous read's data pulse. The command is due two cycles after the last read's data pulse, because one cycle goes to the check. The status write is due the cycle after the mover's completion pulse, and done or err rises at the edge that accepts that write. The ready inputs are stalled at random, so the bench does not count fixed cycles. A monitor samples each port at the falling edge. It checks the payload against the scoreboard queue at every valid-and-ready handshake, and it checks that a stalled valid still holds its payload on the next cycle.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  // word indices inside a descriptor (layout is fixed by the memory format)
  localparam int unsigned W_NXT_LO  = 0;
  localparam int unsigned W_NXT_HI  = 1;
  localparam int unsigned W_BUF_LO  = 2;
  localparam int unsigned W_BUF_HI  = 3;
  localparam int unsigned W_CTRL    = 6;
  localparam int unsigned W_STATUS  = 7;
  localparam int unsigned BASE_WORDS = 8;

  localparam int unsigned LEN_W     = 26;
  localparam int unsigned EOF_BIT   = 26;
  localparam int unsigned SOF_BIT   = 27;
  localparam int unsigned ST_OK_BIT = 31;
  localparam int unsigned ST_ER_BIT = 30;
  localparam int unsigned STRIDE_LG = 6;

  typedef struct packed {
    logic [63:0] nxt;
    logic [63:0] buf_addr;
    logic [27:0] ctrl;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RREQ, S_RWAIT, S_CHECK, S_CMD, S_ACK, S_WSTAT
  } wstate_t;

endpackage

// File: rtl/sgw_desc_capture.sv
module sgw_desc_capture
  import sgw_pkg::*;
#(
  parameter int unsigned IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [31:0]     data,
  output desc_t           desc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc <= '0;
    end else if (we) begin
      case (32'(idx))
        W_NXT_LO: desc.nxt[31:0]       <= data;
        W_NXT_HI: desc.nxt[63:32]      <= data;
        W_BUF_LO: desc.buf_addr[31:0]  <= data;
        W_BUF_HI: desc.buf_addr[63:32] <= data;
        W_CTRL:   desc.ctrl            <= data[27:0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/sgw_desc_check.sv
module sgw_desc_check
  import sgw_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 8
) (
  input  desc_t desc,
  input  logic  is_tail,
  output logic  bad
);
  localparam int unsigned OFFW = $clog2(DATA_BYTES);

  logic len_zero, buf_mis, nxt_mis;

  assign len_zero = (desc.ctrl[LEN_W-1:0] == '0);
  assign nxt_mis  = !is_tail && (desc.nxt[STRIDE_LG-1:0] != '0);

  generate
    if (OFFW == 0) begin : g_no_align
      assign buf_mis = 1'b0;
    end else begin : g_align
      assign buf_mis = (desc.buf_addr[OFFW-1:0] != '0);
    end
  endgenerate

  assign bad = len_zero | buf_mis | nxt_mis;

endmodule

// File: rtl/sgdesc_walker.sv
module sgdesc_walker
  import sgw_pkg::*;
#(
  parameter int unsigned USER_WORDS = 5,
  parameter int unsigned DATA_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] first_addr,
  input  logic [63:0] tail_addr,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [63:0] rd_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [63:0] cmd_addr,
  output logic [25:0] cmd_len,
  output logic        cmd_sof,
  output logic        cmd_eof,
  input  logic        mv_done_valid,
  input  logic [25:0] mv_done_bytes,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [63:0] wr_addr,
  output logic [31:0] wr_data
);
  localparam int unsigned FETCH_WORDS = BASE_WORDS + USER_WORDS;
  localparam int unsigned IDXW        = $clog2(FETCH_WORDS);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FETCH_WORDS - 1);

  wstate_t         state;
  logic [63:0]     cur_q, tail_q;
  logic [IDXW-1:0] idx_q;
  logic [31:0]     stat_q;
  logic            bad_q;
  desc_t           desc;
  logic            is_tail, bad, cap_we;

  assign cap_we  = (state == S_RWAIT) && rd_rsp_valid;
  assign is_tail = (cur_q == tail_q);

  sgw_desc_capture #(.IDXW(IDXW)) u_cap (
    .clk(clk), .rst_n(rst_n), .we(cap_we), .idx(idx_q),
    .data(rd_rsp_data), .desc(desc)
  );

  sgw_desc_check #(.DATA_BYTES(DATA_BYTES)) u_chk (
    .desc(desc), .is_tail(is_tail), .bad(bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur_q  <= '0;
      tail_q <= '0;
      idx_q  <= '0;
      stat_q <= '0;
      bad_q  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cur_q  <= first_addr;
          tail_q <= tail_addr;
          idx_q  <= '0;
          state  <= S_RREQ;
        end
        S_RREQ: if (rd_ready) state <= S_RWAIT;
        S_RWAIT: if (rd_rsp_valid) begin
          if (idx_q == LAST_IDX) begin
            state <= S_CHECK;
          end else begin
            idx_q <= idx_q + 1'b1;
            state <= S_RREQ;
          end
        end
        S_CHECK: begin
          if (bad) begin
            stat_q <= 32'h1 << ST_ER_BIT;
            bad_q  <= 1'b1;
            state  <= S_WSTAT;
          end else begin
            state  <= S_CMD;
          end
        end
        S_CMD: if (cmd_ready) state <= S_ACK;
        S_ACK: if (mv_done_valid) begin
          stat_q <= (32'h1 << ST_OK_BIT) | 32'(mv_done_bytes);
          state  <= S_WSTAT;
        end
        S_WSTAT: if (wr_ready) begin
          if (bad_q) begin
            bad_q <= 1'b0;
            err   <= 1'b1;
            state <= S_IDLE;
          end else if (is_tail) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cur_q <= desc.nxt;
            idx_q <= '0;
            state <= S_RREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign rd_valid  = (state == S_RREQ);
  assign rd_addr   = cur_q + (64'(idx_q) << 2);
  assign cmd_valid = (state == S_CMD);
  assign cmd_addr  = desc.buf_addr;
  assign cmd_len   = desc.ctrl[LEN_W-1:0];
  assign cmd_eof   = desc.ctrl[EOF_BIT];
  assign cmd_sof   = desc.ctrl[SOF_BIT];
  assign wr_valid  = (state == S_WSTAT);
  assign wr_addr   = cur_q + 64'(W_STATUS * 4);
  assign wr_data   = stat_q;

endmodule

module sgw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [63:0] rd_addr,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [63:0] cmd_addr,
  input logic [25:0] cmd_len,
  input logic        cmd_sof,
  input logic        cmd_eof,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [63:0] wr_addr,
  input logic [31:0] wr_data
);
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) &&
      $stable(cmd_len) && $stable(cmd_sof) && $stable(cmd_eof));

  a_r4_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r6_no_zero_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len != 26'd0);

  a_r6_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

bind sgdesc_walker sgw_checker u_sgw_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
  .cmd_len(cmd_len), .cmd_sof(cmd_sof), .cmd_eof(cmd_eof),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sgdesc_walker_bench.sv
module sgdesc_walker_bench;
  localparam int USER_WORDS = 5;
  localparam int FETCH = 8 + USER_WORDS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] first_addr = '0, tail_addr = '0;
  logic        busy, done, err;
  logic        rd_valid, rd_ready;
  logic [63:0] rd_addr;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        cmd_valid, cmd_ready;
  logic [63:0] cmd_addr;
  logic [25:0] cmd_len;
  logic        cmd_sof, cmd_eof;
  logic        mv_done_valid;
  logic [25:0] mv_done_bytes;
  logic        wr_valid, wr_ready;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;

  always #4 clk = ~clk; // 125 MHz

  sgdesc_walker #(.USER_WORDS(USER_WORDS), .DATA_BYTES(8)) u_sgdesc_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
    .tail_addr(tail_addr), .busy(busy), .done(done), .err(err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_sof(cmd_sof), .cmd_eof(cmd_eof),
    .mv_done_valid(mv_done_valid), .mv_done_bytes(mv_done_bytes),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0, failures = 0;
  logic [31:0] mem [0:1023];
  logic [7:0]  lfsr;
  logic [2:0]  mv_cnt;
  logic [25:0] mv_len;
  logic [25:0] short_by = '0;
  int n_done = 0, n_err = 0;

  logic [63:0] exp_rd [$];
  logic [91:0] exp_cmd [$];
  logic [95:0] exp_wr [$];

  task automatic chk(input bit ok, input string req, input logic [95:0] act,
                     input logic [95:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // random back-pressure, memory and mover models
  always @(posedge clk) begin
    if (!rst_n) lfsr <= 8'hA5;
    else lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end
  assign rd_ready  = lfsr[0] | lfsr[3];
  assign cmd_ready = lfsr[2];
  assign wr_ready  = lfsr[5] | lfsr[1];

  always @(posedge clk) begin
    rd_rsp_valid <= rst_n && rd_valid && rd_ready;
    rd_rsp_data  <= mem[rd_addr[11:2]];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mv_cnt <= '0; mv_done_valid <= 1'b0; mv_len <= '0; mv_done_bytes <= '0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        mv_cnt <= 3'd3; mv_len <= cmd_len;
      end else if (mv_cnt != 0) mv_cnt <= mv_cnt - 1'b1;
      mv_done_valid <= (mv_cnt == 3'd1);
      mv_done_bytes <= mv_len - short_by;
    end
  end

  // monitor: scoreboard compare at handshakes, hold checks on stalls
  logic        p_rdv = 0, p_rdr = 0, p_cv = 0, p_cr = 0, p_wv = 0, p_wr = 0;
  logic [63:0] p_rda, p_ca, p_wa;
  logic [25:0] p_cl;
  logic [31:0] p_wd;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) n_done++;
      if (err) n_err++;
      if (p_rdv && !p_rdr)
        chk(rd_valid && rd_addr == p_rda, "R11 rd hold", {31'b0, rd_valid, rd_addr}, {32'h1, p_rda});
      if (p_cv && !p_cr)
        chk(cmd_valid && cmd_addr == p_ca && cmd_len == p_cl, "R3 cmd hold",
            {cmd_addr, 6'b0, cmd_len}, {p_ca, 6'b0, p_cl});
      if (p_wv && !p_wr)
        chk(wr_valid && wr_addr == p_wa && wr_data == p_wd, "R4 wr hold",
            {wr_addr, wr_data}, {p_wa, p_wd});
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) chk(0, "R1 unexpected read", {32'b0, rd_addr}, '0);
        else begin
          logic [63:0] e;
          e = exp_rd.pop_front();
          chk(rd_addr == e, "R1 read address", {32'b0, rd_addr}, {32'b0, e});
        end
      end
      if (cmd_valid && cmd_ready) begin
        if (exp_cmd.size() == 0) chk(0, "R6 unexpected command", {cmd_addr, 4'b0, cmd_len, cmd_sof, cmd_eof}, '0);
        else begin
          logic [91:0] e;
          e = exp_cmd.pop_front();
          chk({cmd_addr, cmd_len, cmd_sof, cmd_eof} == e, "R2 command",
              {4'b0, cmd_addr, cmd_len, cmd_sof, cmd_eof}, {4'b0, e});
        end
      end
      if (wr_valid && wr_ready) begin
        if (exp_wr.size() == 0) chk(0, "R4 unexpected write", {wr_addr, wr_data}, '0);
        else begin
          logic [95:0] e;
          e = exp_wr.pop_front();
          chk({wr_addr, wr_data} == e, "R4 status write", {wr_addr, wr_data}, e);
        end
      end
    end
    p_rdv <= rd_valid; p_rdr <= rd_ready; p_rda <= rd_addr;
    p_cv <= cmd_valid; p_cr <= cmd_ready; p_ca <= cmd_addr; p_cl <= cmd_len;
    p_wv <= wr_valid; p_wr <= wr_ready; p_wa <= wr_addr; p_wd <= wr_data;
  end

  // driver: build a descriptor in memory and push what it must produce
  task automatic put_desc(input logic [63:0] base, input logic [63:0] nxt,
                          input logic [63:0] bufa, input logic [31:0] ctrl,
                          input bit bad);
    for (int i = 0; i < 16; i++) mem[base[11:2] + i] = 32'hDEAD_0000 + i;
    mem[base[11:2] + 0] = nxt[31:0];
    mem[base[11:2] + 1] = nxt[63:32];
    mem[base[11:2] + 2] = bufa[31:0];
    mem[base[11:2] + 3] = bufa[63:32];
    mem[base[11:2] + 6] = ctrl;
    for (int i = 0; i < FETCH; i++) exp_rd.push_back(base + 64'(4 * i));
    if (bad) exp_wr.push_back({base + 64'h1C, 32'h4000_0000});
    else begin
      exp_cmd.push_back({bufa, ctrl[25:0], ctrl[27], ctrl[26]});
      exp_wr.push_back({base + 64'h1C, 32'h8000_0000 | 32'(ctrl[25:0] - short_by)});
    end
  endtask

  task automatic run(input logic [63:0] f, input logic [63:0] t, input int want_done,
                     input int want_err, input bit poke_busy, input string tag);
    int d0, e0, guard;
    d0 = n_done; e0 = n_err;
    @(negedge clk);
    first_addr = f; tail_addr = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", {95'b0, busy}, 96'h1);
    if (poke_busy) begin
      repeat (30) @(negedge clk);
      first_addr = 64'h300; tail_addr = 64'h300; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy kept during ignored start", {95'b0, busy}, 96'h1);
    end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    chk(guard < 20000, {tag, " watchdog"}, 96'(guard), 96'd0);
    @(negedge clk);
    chk(n_done - d0 == want_done, {tag, " done pulses"}, 96'(n_done - d0), 96'(want_done));
    chk(n_err - e0 == want_err, {tag, " err pulses"}, 96'(n_err - e0), 96'(want_err));
    chk(exp_rd.size() == 0 && exp_cmd.size() == 0 && exp_wr.size() == 0,
        {tag, " scoreboard drained"},
        96'(exp_rd.size() + exp_cmd.size() + exp_wr.size()), 96'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rd_valid && !cmd_valid && !wr_valid, "R10 reset state",
        {90'b0, busy, done, err, rd_valid, cmd_valid, wr_valid}, 96'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_valid, "R10 idle after reset", {94'b0, busy, rd_valid}, 96'd0);

    // R1 R2 R5 R8 R9: three-buffer frame, tail carries an unaligned next pointer
    put_desc(64'h100, 64'h140, 64'h1_0000_2000, 32'h0800_0064, 0);
    put_desc(64'h140, 64'h180, 64'h1_0000_3008, 32'h0000_0800, 0);
    put_desc(64'h180, 64'h123, 64'h2_0000_4010, 32'h0400_0007, 0);
    run(64'h100, 64'h180, 1, 0, 1, "R5 chain");

    // R4 R2: maximum length, single-buffer frame, mover reports fewer bytes
    short_by = 26'd5;
    put_desc(64'h1C0, 64'h0, 64'h0000_0000_8000_0000, 32'h0FFF_FFFF, 0);
    run(64'h1C0, 64'h1C0, 1, 0, 0, "R4 max length");
    short_by = 26'd0;

    // R6: zero length halts
    put_desc(64'h200, 64'h240, 64'h5000, 32'h0C00_0000, 1);
    run(64'h200, 64'h240, 0, 1, 0, "R6 zero length");

    // R7: second descriptor has a misaligned buffer
    put_desc(64'h240, 64'h280, 64'h6000, 32'h0800_0010, 0);
    put_desc(64'h280, 64'h2C0, 64'h3004, 32'h0400_0010, 1);
    run(64'h240, 64'h2C0, 0, 1, 0, "R7 misaligned buffer");

    // R8: non-tail descriptor with unaligned next pointer
    put_desc(64'h2C0, 64'h2C8, 64'h7000, 32'h0C00_0020, 1);
    run(64'h2C0, 64'h300, 0, 1, 0, "R8 misaligned next");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule